// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block lets synchronous logic use an external asynchronous static RAM of 524,288 sixteen-bit words. The host side is a simple request/acknowledge port. A request carries a 19-bit word address, 16 bits of write data, a two-bit lane mask and a read/write flag. The controller accepts one request at a time. It returns a single-cycle acknowledge when the memory access is complete, together with read data for reads.

On the memory side the controller drives one active-low chip select, write and output strobes, and one active-low enable for each byte lane. The data pins are split into an output word, an output-enable and an input word, so that the pad ring can build the bidirectional buffer. Writes are strobe-timed: data is committed when the write strobe rises while the address stays held. Reads are timed by the output strobe.

The length of every phase is derived from nanosecond timing parameters and a clock-period parameter. Each length is the ceiling of the time divided by the clock period, and never less than one cycle. Bus ownership is sequenced so that the controller and the memory never drive the data pins together.

Top module: `asram_lane_ctrl`

## Requirements
- R1: While reset is active and after it is released, chip select and both strobes are high, the data bus is released, `req_ready` is 1 and `rsp_ack` is 0.
- R2: Lane mask bit 0 selects data bits 7:0 through `mem_lb_n`, and mask bit 1 selects bits 15:8 through `mem_ub_n`. A write changes only the bytes whose lane is selected.
- R3: `mem_we_n` stays low for at least ceil(T_WP_NS/CLK_NS) cycles (5 with the defaults, because of the release gap of R7). Write data is driven without a break for at least ceil(T_DW_NS/CLK_NS) cycles (3) up to the rise of `mem_we_n`.
- R4: Address and lane enables do not change in any cycle in which `mem_cs_n` and `mem_we_n` were both low in the cycle before and are both still low.
- R5: A read holds `mem_cs_n` and `mem_oe_n` low with `mem_we_n` high for max(ceil(T_AA_NS/CLK_NS), ceil(T_OE_NS/CLK_NS)) cycles (6). Data is registered at the end of the last of those cycles. Bytes of lanes not selected read as zero.
- R6: `req_ready` is high only while idle, and a request is taken in a cycle with `req_valid` and `req_ready` both high. `rsp_ack` is a one-cycle pulse in the cycle after the final phase cycle, and `rsp_rdata` is valid in that cycle.
- R7: `mem_dq_oe` is high only while `mem_we_n` is low, `mem_oe_n` is high, and at least ceil(T_WZ_NS/CLK_NS) cycles (2) have passed since `mem_we_n` fell. It is never high while the memory may drive the bus.
- R8: When a write follows a read, chip select stays high for at least two cycles between the end of the read and the start of the write. These are the idle cycle and one turnaround cycle.
- R9: A request with lane mask 00 keeps both lane enables high. A write with it leaves the stored data unchanged, and a read with it returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select: bit 0 low byte, bit 1 high byte |
| rsp_ack | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 16 | Read data, masked per lane |
| mem_addr | output | 19 | Memory address pins |
| mem_cs_n | output | 1 | Chip select, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output strobe, active low |
| mem_lb_n | output | 1 | Low byte lane enable, active low |
| mem_ub_n | output | 1 | High byte lane enable, active low |
| mem_dq_out | output | 16 | Data toward the memory |
| mem_dq_oe | output | 1 | Drive enable for the data pins |
| mem_dq_in | input | 16 | Data from the memory pins |

## Verification
The cycle that acknowledges a read is also the cycle in which the host may present the next request. A write accepted there must not drive the pins while the memory output is still releasing. The bench provokes this on every read-then-write pair of its sweep by issuing the next request in the acknowledge cycle. A memory model counts every cycle in which both sides drive the bus, and measures the chip-select-high gap before the write.

// File: rtl/asram_pkg.sv
package asram_pkg;

    localparam int unsigned WORD_AW = 19;
    localparam int unsigned WORD_DW = 16;
    localparam int unsigned LANES   = 2;
    localparam int unsigned LANE_W  = WORD_DW / LANES;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_TURN,
        PH_WSET,
        PH_WPUL,
        PH_WREC,
        PH_RACC
    } phase_e;

    typedef struct packed {
        logic               is_write;
        logic [LANES-1:0]   lanes;
        logic [WORD_AW-1:0] addr;
        logic [WORD_DW-1:0] wdata;
    } xfer_t;

    // ceiling of t/clk, at least one cycle
    function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                                 input int unsigned clk_ns);
        int unsigned q;
        q = (t_ns + clk_ns - 1) / clk_ns;
        return (q == 0) ? 1 : q;
    endfunction

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/asram_phase_timer.sv
module asram_phase_timer #(
    parameter int unsigned CW = 3
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic [CW-1:0] remain,
    output logic          expired
);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (load) begin
            remain <= load_val;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

    assign expired = (remain == '0);

endmodule

// File: rtl/asram_sequencer.sv
module asram_sequencer
    import asram_pkg::*;
#(
    parameter int unsigned CW      = 3,
    parameter int unsigned PUL_LEN = 5,
    parameter int unsigned REC_LEN = 1,
    parameter int unsigned RD_LEN  = 6
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          start_wr,
    input  logic          expired,
    output phase_e        phase,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          wr_fin,
    output logic          rd_fin
);

    localparam logic [CW-1:0] PUL_LAST = CW'(PUL_LEN - 1);
    localparam logic [CW-1:0] REC_LAST = CW'(REC_LEN - 1);
    localparam logic [CW-1:0] RD_LAST  = CW'(RD_LEN - 1);

    phase_e nxt;
    logic   after_rd;

    always_comb begin
        nxt      = phase;
        load     = 1'b0;
        load_val = '0;
        wr_fin   = 1'b0;
        rd_fin   = 1'b0;
        unique case (phase)
            PH_IDLE: begin
                if (start) begin
                    load = 1'b1;
                    if (start_wr) begin
                        nxt = after_rd ? PH_TURN : PH_WSET;
                    end else begin
                        nxt      = PH_RACC;
                        load_val = RD_LAST;
                    end
                end
            end
            PH_TURN: begin
                if (expired) begin
                    nxt  = PH_WSET;
                    load = 1'b1;
                end
            end
            PH_WSET: begin
                if (expired) begin
                    nxt      = PH_WPUL;
                    load     = 1'b1;
                    load_val = PUL_LAST;
                end
            end
            PH_WPUL: begin
                if (expired) begin
                    nxt      = PH_WREC;
                    load     = 1'b1;
                    load_val = REC_LAST;
                end
            end
            PH_WREC: begin
                if (expired) begin
                    nxt    = PH_IDLE;
                    wr_fin = 1'b1;
                end
            end
            PH_RACC: begin
                if (expired) begin
                    nxt    = PH_IDLE;
                    rd_fin = 1'b1;
                end
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_IDLE;
            after_rd <= 1'b0;
        end else begin
            phase <= nxt;
            if (rd_fin) begin
                after_rd <= 1'b1;
            end else if (phase == PH_WSET) begin
                after_rd <= 1'b0;
            end
        end
    end

    // R6: a completion is never reported while a new request is being taken
    a_r6_fin_idle: assert property (@(posedge clk) disable iff (rst)
        (wr_fin || rd_fin) |=> (phase == PH_IDLE));

endmodule

// File: rtl/asram_lane_path.sv
module asram_lane_path
    import asram_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               take,
    input  xfer_t              xin,
    input  logic               grab,
    input  logic [WORD_DW-1:0] dq_in,
    output logic [WORD_AW-1:0] addr,
    output logic [LANES-1:0]   lanes,
    output logic [WORD_DW-1:0] wdata,
    output logic [WORD_DW-1:0] rdata
);

    logic held_wr;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr    <= '0;
            lanes   <= '0;
            wdata   <= '0;
            held_wr <= 1'b0;
        end else if (take) begin
            addr    <= xin.addr;
            lanes   <= xin.lanes;
            wdata   <= xin.wdata;
            held_wr <= xin.is_write;
        end
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] byte_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
            end else if (grab && !held_wr) begin
                byte_q <= lanes[g] ? dq_in[g*LANE_W +: LANE_W] : '0;
            end
        end
        assign rdata[g*LANE_W +: LANE_W] = byte_q;
    end

    // R4: the held request only changes when a new one is taken
    a_r4_hold_stable: assert property (@(posedge clk) disable iff (rst)
        !$past(take) |-> ($stable(addr) && $stable(lanes) && $stable(wdata)));

endmodule

// File: rtl/asram_lane_ctrl.sv
module asram_lane_ctrl
    import asram_pkg::*;
#(
    parameter int unsigned CLK_NS  = 10,
    parameter int unsigned T_WC_NS = 55,
    parameter int unsigned T_WP_NS = 35,
    parameter int unsigned T_DW_NS = 25,
    parameter int unsigned T_WZ_NS = 20,
    parameter int unsigned T_AA_NS = 55,
    parameter int unsigned T_OE_NS = 25
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    output logic               req_ready,
    input  logic               req_write,
    input  logic [WORD_AW-1:0] req_addr,
    input  logic [WORD_DW-1:0] req_wdata,
    input  logic [LANES-1:0]   req_mask,
    output logic               rsp_ack,
    output logic [WORD_DW-1:0] rsp_rdata,
    output logic [WORD_AW-1:0] mem_addr,
    output logic               mem_cs_n,
    output logic               mem_we_n,
    output logic               mem_oe_n,
    output logic               mem_lb_n,
    output logic               mem_ub_n,
    output logic [WORD_DW-1:0] mem_dq_out,
    output logic               mem_dq_oe,
    input  logic [WORD_DW-1:0] mem_dq_in
);

    localparam int unsigned WC_CYC   = ns_to_cycles(T_WC_NS, CLK_NS);
    localparam int unsigned WP_CYC   = ns_to_cycles(T_WP_NS, CLK_NS);
    localparam int unsigned DW_CYC   = ns_to_cycles(T_DW_NS, CLK_NS);
    localparam int unsigned WZ_CYC   = ns_to_cycles(T_WZ_NS, CLK_NS);
    localparam int unsigned AA_CYC   = ns_to_cycles(T_AA_NS, CLK_NS);
    localparam int unsigned OE_CYC   = ns_to_cycles(T_OE_NS, CLK_NS);
    localparam int unsigned PUL_CYC  = max2(WP_CYC, WZ_CYC + DW_CYC);
    localparam int unsigned REC_CYC  = (WC_CYC > PUL_CYC + 1) ? (WC_CYC - PUL_CYC - 1) : 1;
    localparam int unsigned RD_CYC   = max2(AA_CYC, OE_CYC);
    localparam int unsigned SPAN     = max2(max2(PUL_CYC, REC_CYC), RD_CYC);
    localparam int unsigned CW       = $clog2(SPAN + 1);
    localparam int unsigned DRV_LAST = PUL_CYC - 1 - WZ_CYC;
    localparam int unsigned RUN_W    = 8;

    phase_e             phase;
    logic               accept;
    logic               tmr_load;
    logic [CW-1:0]      tmr_val;
    logic [CW-1:0]      tmr_left;
    logic               tmr_zero;
    logic               wr_fin;
    logic               rd_fin;
    xfer_t              req_x;
    logic [LANES-1:0]   hold_lanes;
    logic [LANES-1:0]   lane_n;
    logic               sel_chip;

    assign req_ready = (phase == PH_IDLE);
    assign accept    = req_valid && req_ready;

    always_comb begin
        req_x.is_write = req_write;
        req_x.lanes    = req_mask;
        req_x.addr     = req_addr;
        req_x.wdata    = req_wdata;
    end

    asram_sequencer #(
        .CW     (CW),
        .PUL_LEN(PUL_CYC),
        .REC_LEN(REC_CYC),
        .RD_LEN (RD_CYC)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .start   (accept),
        .start_wr(req_write),
        .expired (tmr_zero),
        .phase   (phase),
        .load    (tmr_load),
        .load_val(tmr_val),
        .wr_fin  (wr_fin),
        .rd_fin  (rd_fin)
    );

    asram_phase_timer #(.CW(CW)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .remain  (tmr_left),
        .expired (tmr_zero)
    );

    asram_lane_path u_lanes (
        .clk  (clk),
        .rst  (rst),
        .take (accept),
        .xin  (req_x),
        .grab (rd_fin),
        .dq_in(mem_dq_in),
        .addr (mem_addr),
        .lanes(hold_lanes),
        .wdata(mem_dq_out),
        .rdata(rsp_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_ack <= 1'b0;
        end else begin
            rsp_ack <= wr_fin || rd_fin;
        end
    end

    // pin decode
    assign sel_chip = (phase == PH_WSET) || (phase == PH_WPUL) || (phase == PH_RACC);
    assign mem_cs_n = !sel_chip;
    assign mem_we_n = (phase != PH_WPUL);
    assign mem_oe_n = (phase != PH_RACC);

    for (genvar g = 0; g < LANES; g++) begin : g_en
        assign lane_n[g] = !(sel_chip && hold_lanes[g]);
    end
    assign mem_lb_n = lane_n[0];
    assign mem_ub_n = lane_n[1];

    // drive only once the memory has had its release time after the strobe fell
    assign mem_dq_oe = (phase == PH_WPUL) && (tmr_left <= CW'(DRV_LAST));

    // run counters used by the checks below
    logic [RUN_W-1:0] we_lo_run;
    logic [RUN_W-1:0] drv_run;
    logic [2:0]       cs_hi_run;
    logic             rd_mark;

    always_ff @(posedge clk) begin
        if (rst) begin
            we_lo_run <= '0;
            drv_run   <= '0;
            cs_hi_run <= '0;
            rd_mark   <= 1'b0;
        end else begin
            we_lo_run <= !mem_we_n ? ((we_lo_run == '1) ? we_lo_run : we_lo_run + 1'b1) : '0;
            drv_run   <= mem_dq_oe ? ((drv_run == '1) ? drv_run : drv_run + 1'b1) : '0;
            cs_hi_run <= mem_cs_n ? ((cs_hi_run == '1) ? cs_hi_run : cs_hi_run + 1'b1) : '0;
            if (!mem_oe_n) begin
                rd_mark <= 1'b1;
            end else if (!mem_cs_n) begin
                rd_mark <= 1'b0;
            end
        end
    end

    a_r1_reset_exit: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (mem_cs_n && mem_we_n && mem_oe_n && !mem_dq_oe && req_ready && !rsp_ack));

    a_r3_pulse_width: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (we_lo_run >= RUN_W'(WP_CYC)));

    a_r3_data_setup: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_we_n) |-> (drv_run >= RUN_W'(DW_CYC)));

    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (!mem_cs_n && !mem_we_n && $past(!mem_cs_n && !mem_we_n))
        |-> ($stable(mem_addr) && $stable(mem_lb_n) && $stable(mem_ub_n)));

    a_r5_read_shape: assert property (@(posedge clk) disable iff (rst)
        !mem_oe_n |-> (mem_we_n && !mem_cs_n && !mem_dq_oe));

    a_r6_ack_single: assert property (@(posedge clk) disable iff (rst)
        rsp_ack |=> !rsp_ack);

    a_r7_drive_gap: assert property (@(posedge clk) disable iff (rst)
        mem_dq_oe |-> (!mem_we_n && mem_oe_n && (we_lo_run >= RUN_W'(WZ_CYC))));

    a_r8_turnaround: assert property (@(posedge clk) disable iff (rst)
        (rd_mark && $fell(mem_cs_n) && mem_oe_n) |-> (cs_hi_run >= 3'd2));

endmodule

// File: tb/asram_lane_ctrl_test.sv
module asram_lane_ctrl_test;

    localparam int CLK_NS = 10;
    localparam int TB_WP  = (35 + CLK_NS - 1) / CLK_NS;
    localparam int TB_DW  = (25 + CLK_NS - 1) / CLK_NS;
    localparam int TB_AA  = (55 + CLK_NS - 1) / CLK_NS;
    localparam int TB_OE  = (25 + CLK_NS - 1) / CLK_NS;
    localparam int TB_RD  = (TB_AA > TB_OE) ? TB_AA : TB_OE;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [18:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_ack;
    logic [15:0] rsp_rdata;
    logic [18:0] mem_addr;
    logic        mem_cs_n, mem_we_n, mem_oe_n, mem_lb_n, mem_ub_n;
    logic [15:0] mem_dq_out;
    logic        mem_dq_oe;
    logic [15:0] mem_dq_in;

    int total = 0;
    int bad   = 0;

    always #(CLK_NS / 2) clk = ~clk;

    asram_lane_ctrl #(.CLK_NS(CLK_NS)) uut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_mask(req_mask),
        .rsp_ack(rsp_ack), .rsp_rdata(rsp_rdata),
        .mem_addr(mem_addr), .mem_cs_n(mem_cs_n), .mem_we_n(mem_we_n),
        .mem_oe_n(mem_oe_n), .mem_lb_n(mem_lb_n), .mem_ub_n(mem_ub_n),
        .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_dq_in(mem_dq_in)
    );

    // ---------------- behavioural memory and bus monitor ----------------
    logic [15:0] marr [8];
    logic        l_we = 1'b1, l_cs = 1'b1, l_drv = 1'b0, l_rd = 1'b0, l_ack = 1'b0;
    logic [18:0] l_addr = '0;
    logic [1:0]  l_lanes_n = 2'b11;
    logic [15:0] l_dq = '0;
    int acc = 0, we_run = 0, drv_run = 0, gap = 0;
    bit rd_seen = 0;
    int cont_bad = 0, addr_bad = 0, pw_bad = 0, setup_bad = 0, nodata_bad = 0;
    int map_bad = 0, turn_bad = 0, turn_seen = 0, ack_bad = 0, commits = 0;

    wire mem_rd = !mem_cs_n && !mem_oe_n && mem_we_n && !(mem_lb_n && mem_ub_n);

    always_comb begin
        if (mem_rd && acc >= TB_RD) begin
            mem_dq_in[7:0]  = mem_lb_n ? 8'hA5 : marr[mem_addr[2:0]][7:0];
            mem_dq_in[15:8] = mem_ub_n ? 8'h5A : marr[mem_addr[2:0]][15:8];
        end else begin
            mem_dq_in = 16'hDEAD;
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (mem_dq_oe && (mem_rd || l_rd)) cont_bad++;
            if (!l_cs && !l_we && !mem_cs_n && !mem_we_n &&
                (mem_addr != l_addr || {mem_ub_n, mem_lb_n} != l_lanes_n)) addr_bad++;
            if (!l_cs && !l_we && mem_we_n) begin
                commits++;
                if (we_run < TB_WP) pw_bad++;
                if (!l_drv) nodata_bad++;
                if (drv_run < TB_DW) setup_bad++;
                if (l_addr[18:16] != l_addr[2:0] ||
                    !(l_addr[15:3] == 13'h0 || l_addr[15:3] == 13'h1FFF)) map_bad++;
                if (!l_lanes_n[0]) marr[l_addr[2:0]][7:0]  = l_dq[7:0];
                if (!l_lanes_n[1]) marr[l_addr[2:0]][15:8] = l_dq[15:8];
            end
            if (!mem_oe_n) begin
                rd_seen = 1;
                gap = 0;
            end else if (mem_cs_n) begin
                gap++;
            end
            if (rd_seen && !mem_we_n && l_we) begin
                turn_seen++;
                if (gap < 2) turn_bad++;
                rd_seen = 0;
            end
            if (!mem_we_n && mem_oe_n && !mem_cs_n) rd_seen = 0;
            if (rsp_ack && l_ack) ack_bad++;
            acc     = mem_rd ? acc + 1 : 0;
            we_run  = !mem_we_n ? we_run + 1 : 0;
            drv_run = mem_dq_oe ? drv_run + 1 : 0;
        end
        l_we      = mem_we_n;
        l_cs      = mem_cs_n;
        l_drv     = mem_dq_oe;
        l_rd      = mem_rd;
        l_ack     = rsp_ack;
        l_addr    = mem_addr;
        l_lanes_n = {mem_ub_n, mem_lb_n};
        l_dq      = mem_dq_out;
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lane_bits(input logic [1:0] m);
        return {(m[1] ? 8'hFF : 8'h00), (m[0] ? 8'hFF : 8'h00)};
    endfunction

    function automatic logic [18:0] addr_of(input int i);
        logic [2:0] k;
        k = 3'(i);
        return {k, (k == 3'd7) ? 13'h1FFF : 13'h0, k};
    endfunction

    // called at a falling edge; returns at the falling edge that shows the ack
    task automatic do_req(input logic wr, input logic [18:0] a, input logic [15:0] d,
                          input logic [1:0] m, output logic [15:0] rd);
        int guard;
        req_write = wr;
        req_addr  = a;
        req_wdata = d;
        req_mask  = m;
        req_valid = 1'b1;
        guard = 0;
        while (!req_ready && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready, "R6 busy ready", 32'(req_ready), 32'h0);
        guard = 0;
        while (!rsp_ack && guard < 100) begin
            @(negedge clk);
            guard++;
        end
        chk(guard < 100, "R6 ack arrives", 32'(guard), 32'd100);
        rd = rsp_rdata;
    endtask

    logic [15:0] shadow [8];

    initial begin
        #(CLK_NS * 150000);
        bad++;
        total++;
        $display("FAIL watchdog actual=expired expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] got;
        logic [15:0] pat;
        logic [1:0]  rmask;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(mem_cs_n && mem_we_n && mem_oe_n, "R1 strobes in reset",
            {29'h0, mem_cs_n, mem_we_n, mem_oe_n}, 32'h7);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_cs_n && !mem_dq_oe, "R1 idle bus", {30'h0, mem_cs_n, mem_dq_oe}, 32'h2);
        chk(req_ready && !rsp_ack, "R1 idle handshake", {30'h0, req_ready, rsp_ack}, 32'h2);

        for (int i = 0; i < 8; i++) begin
            pat = 16'h0F0F ^ (16'(i) * 16'h1111);
            do_req(1'b1, addr_of(i), pat, 2'b11, got);
            shadow[i] = pat;
        end

        for (int w = 0; w < 4; w++) begin
            for (int i = 0; i < 8; i++) begin
                pat = (16'(i) * 16'h0F1D) ^ (16'(w) * 16'h2211) ^ 16'h8C3A;
                do_req(1'b1, addr_of(i), pat, 2'(w), got);
                shadow[i] = (shadow[i] & ~lane_bits(2'(w))) | (pat & lane_bits(2'(w)));
                do_req(1'b0, addr_of(i), 16'h0, 2'b11, got);
                if (w == 0)
                    chk(got == shadow[i], "R9 empty-mask write", 32'(got), 32'(shadow[i]));
                else
                    chk(got == shadow[i], "R2 lane write readback", 32'(got), 32'(shadow[i]));
                rmask = 2'((i + w) % 3);
                do_req(1'b0, addr_of(i), 16'h0, rmask, got);
                if (rmask == 2'b00)
                    chk(got == 16'h0, "R9 empty-mask read", 32'(got), 32'h0);
                else
                    chk(got == (shadow[i] & lane_bits(rmask)), "R5 masked read",
                        32'(got), 32'(shadow[i] & lane_bits(rmask)));
            end
        end
        @(negedge clk);
        @(negedge clk);

        chk(cont_bad == 0, "R7 bus contention cycles", 32'(cont_bad), 32'h0);
        chk(addr_bad == 0, "R4 address moved in write", 32'(addr_bad), 32'h0);
        chk(map_bad == 0, "R4 committed address", 32'(map_bad), 32'h0);
        chk(pw_bad == 0, "R3 short write pulse", 32'(pw_bad), 32'h0);
        chk(setup_bad == 0 && nodata_bad == 0, "R3 data setup",
            32'(setup_bad + nodata_bad), 32'h0);
        chk(commits == 40, "R3 write commits", 32'(commits), 32'd40);
        chk(turn_seen > 0 && turn_bad == 0, "R8 read-to-write turnaround",
            32'(turn_bad), 32'h0);
        chk(ack_bad == 0, "R6 ack longer than one cycle", 32'(ack_bad), 32'h0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule